// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block watches 32 external pins and turns their activity into interrupt requests. The pins are grouped into four banks of eight. Every pin first passes through a two-flop synchroniser. A per-line trigger selector then decides whether a level or an edge on the synchronised signal counts as an event. An event latches a sticky pending flag, and software acknowledges it by writing a one to that flag.

The sixteen lowest lines each drive an interrupt output of their own whenever they are pending and not masked. The sixteen upper lines share one output. An information word names the highest-numbered upper line that is currently pending and unmasked, so a handler always takes the highest line first.

Software reaches the block through a small word-addressed port with a combinational read path. The word address is four bits wide: bits [3:2] pick a register group (0 trigger modes, 1 masks, 2 pending, 3 information) and bits [1:0] pick the bank. Line k belongs to bank k/8, at position k%8 within it.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset, all pending flags are 0, all mask bits are 1, every trigger-mode field is 0, both interrupt outputs are low and the information word reads 0.
- R2: In a bank's mode word, line position p owns bits [4p+2:4p] as its trigger code. Bit 4p+3 is ignored on write and reads back as 0.
- R3: Trigger code 0 (level low) and code 1 (level high) set the pending flag on every cycle in which the synchronised pin sits at the active level. A clear written while the level is still active leaves the flag at 1.
- R4: Code 2 (falling), code 3 (rising) and code 4 (either edge) set the pending flag only when the synchronised sample differs from the previous sample in the selected direction. A steady pin does not set the flag again after a clear.
- R5: Codes 5, 6 and 7 never set a pending flag.
- R6: A write to a bank's pending word clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A new event in the same cycle wins over the clear.
- R7: A mask bit of 1 keeps its line off every output and out of the information word. The pending flag still records events while the line is masked.
- R8: Output direct_irq[k] for lines 0 to 15 is high exactly while line k is pending and unmasked.
- R9: shared_irq is high exactly while at least one of lines 16 to 31 is pending and unmasked.
- R10: The information word (group 3, bank 0) carries bit 8 as a valid flag and bits [4:0] as the absolute number of the highest-numbered pending unmasked line among 16 to 31. When no such line exists, the word is 0.
- R11: A pin change driven just after one rising clock edge shows in the pending flag after the third rising edge. It is not yet visible after the second.
- R12: Mask and pending words use only data bits [7:0]. Upper bits are ignored on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Asynchronous external pins, one per line |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Word address: [3:2] group, [1:0] bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| direct_irq | output | 16 | Dedicated requests for lines 0 to 15 |
| shared_irq | output | 1 | Combined request for lines 16 to 31 |

## Verification
The bench builds the block with its default parameters: four banks of eight lines, with the two lower banks wired to dedicated outputs. This puts every trigger code, including the disabled codes, on a real line in each half. It also allows two upper lines in different banks to be pending together, so the highest-first pick is exercised across a bank boundary. Because the synchroniser resets to the high level and the pins idle high, the level-low reset mode stays quiet, and the bench can count the three-edge latency exactly on a rising-edge line.

// File: rtl/pec_pkg.sv
package pec_pkg;

  localparam int BUS_W  = 32;
  localparam int SLOT_W = 4;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    TRIG_LVL_LO = 3'd0,
    TRIG_LVL_HI = 3'd1,
    TRIG_FALL   = 3'd2,
    TRIG_RISE   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  typedef enum logic [1:0] {
    GRP_MODE = 2'd0,
    GRP_MASK = 2'd1,
    GRP_PEND = 2'd2,
    GRP_INFO = 2'd3
  } grp_e;

  // Event decision for one line from its code and two successive samples.
  function automatic logic trig_hit(logic [CODE_W-1:0] code, logic cur, logic prev);
    logic r;
    case (code)
      TRIG_LVL_LO: r = ~cur;
      TRIG_LVL_HI: r = cur;
      TRIG_FALL:   r = prev & ~cur;
      TRIG_RISE:   r = ~prev & cur;
      TRIG_BOTH:   r = prev ^ cur;
      default:     r = 1'b0;
    endcase
    return r;
  endfunction

  // Trigger code of slot k inside a mode word.
  function automatic logic [CODE_W-1:0] slot_code(logic [BUS_W-1:0] w, int k);
    return w[k*SLOT_W +: CODE_W];
  endfunction

endpackage

// File: rtl/pec_sync.sv
module pec_sync #(
  parameter int   W       = 32,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      cur_q  <= {W{RST_VAL}};
      prev_q <= {W{RST_VAL}};
    end else begin
      meta_q <= din;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/pec_line_detect.sv
module pec_line_detect
  import pec_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              cur_i,
  input  logic              prev_i,
  output logic              hit_o
);
  assign hit_o = trig_hit(code_i, cur_i, prev_i);
endmodule

// File: rtl/pec_bank.sv
module pec_bank
  import pec_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] cur_i,
  input  logic [LINES-1:0] prev_i,
  input  logic             wr_mode_i,
  input  logic             wr_mask_i,
  input  logic             wr_clr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] mode_word_o,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] pend_o
);
  localparam int SLOTS = BUS_W / SLOT_W;

  logic [CODE_W-1:0] code_q [LINES];
  logic [LINES-1:0]  hit;
  logic [LINES-1:0]  clr_mask;
  logic [LINES-1:0]  mask_q, pend_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < LINES) begin : g_line
      pec_line_detect u_det (
        .code_i (code_q[g]),
        .cur_i  (cur_i[g]),
        .prev_i (prev_i[g]),
        .hit_o  (hit[g])
      );

      always_ff @(posedge clk) begin
        if (!rst_n)         code_q[g] <= TRIG_LVL_LO;
        else if (wr_mode_i) code_q[g] <= slot_code(wdata_i, g);
      end

      assign mode_word_o[g*SLOT_W +: SLOT_W] = {1'b0, code_q[g]};

      // R3: an active low level is latched on the next edge
      p_lvl_lo_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q[g] == TRIG_LVL_LO && !cur_i[g]) |=> pend_q[g]);
      // R4: a rising step on a rising-edge line is latched on the next edge
      p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q[g] == TRIG_RISE && cur_i[g] && !prev_i[g]) |=> pend_q[g]);
      // R5: disabled codes never raise a flag
      p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q[g] > 3'd4) |=> !(pend_q[g] && !$past(pend_q[g])));
    end else begin : g_pad
      assign mode_word_o[g*SLOT_W +: SLOT_W] = '0;
    end
  end

  assign clr_mask = wr_clr_i ? wdata_i[LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (wr_mask_i) mask_q <= wdata_i[LINES-1:0];
      pend_q <= (pend_q & ~clr_mask) | hit;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  // R6: a flag not being cleared stays set
  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_mask)) == $past(pend_q & ~clr_mask)));
  // R4: a flag only rises when its detector reported an event
  p_pend_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/pec_pick.sv
module pec_pick #(
  parameter int W     = 16,
  parameter int BASE  = 16,
  parameter int IDX_W = 5
) (
  input  logic [W-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // Ascending scan: the last set bit found is the highest one.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(BASE + i);
      end
    end
  end
endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pec_pkg::*;
#(
  parameter int  NUM_BANKS    = 4,
  parameter int  BANK_LINES   = 8,
  parameter int  DIRECT_BANKS = 2,
  parameter int  VALID_BIT    = 8,
  localparam int NUM_LINES    = NUM_BANKS * BANK_LINES,
  localparam int DIRECT_LINES = DIRECT_BANKS * BANK_LINES,
  localparam int BSEL_W       = $clog2(NUM_BANKS),
  localparam int ADDR_W       = BSEL_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_LINES-1:0]    pin_in,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  output logic [DIRECT_LINES-1:0] direct_irq,
  output logic                    shared_irq
);
  localparam int SHARED_LINES = NUM_LINES - DIRECT_LINES;
  localparam int IDX_W        = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0]    cur, prev;
  logic [NUM_LINES-1:0]    mask_all, pend_all, active;
  logic [BUS_W-1:0]        mode_word [NUM_BANKS];
  logic [SHARED_LINES-1:0] shared_req;
  logic                    top_valid;
  logic [IDX_W-1:0]        top_idx;
  logic [BUS_W-1:0]        info_word;
  logic [1:0]              grp;
  logic [BSEL_W-1:0]       bsel;

  assign grp  = bus_addr[ADDR_W-1 -: 2];
  assign bsel = bus_addr[BSEL_W-1:0];

  pec_sync #(.W(NUM_LINES), .RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (pin_in),
    .cur_o  (cur),
    .prev_o (prev)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_b;
    assign sel_b = bus_wr && (bsel == BSEL_W'(b));

    pec_bank #(.LINES(BANK_LINES)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .cur_i       (cur[b*BANK_LINES +: BANK_LINES]),
      .prev_i      (prev[b*BANK_LINES +: BANK_LINES]),
      .wr_mode_i   (sel_b && grp == GRP_MODE),
      .wr_mask_i   (sel_b && grp == GRP_MASK),
      .wr_clr_i    (sel_b && grp == GRP_PEND),
      .wdata_i     (bus_wdata),
      .mode_word_o (mode_word[b]),
      .mask_o      (mask_all[b*BANK_LINES +: BANK_LINES]),
      .pend_o      (pend_all[b*BANK_LINES +: BANK_LINES])
    );
  end

  assign active     = pend_all & ~mask_all;
  assign direct_irq = active[DIRECT_LINES-1:0];
  assign shared_req = active[NUM_LINES-1:DIRECT_LINES];
  assign shared_irq = |shared_req;

  pec_pick #(.W(SHARED_LINES), .BASE(DIRECT_LINES), .IDX_W(IDX_W)) u_pick (
    .req_i   (shared_req),
    .valid_o (top_valid),
    .idx_o   (top_idx)
  );

  always_comb begin
    info_word = '0;
    if (top_valid) begin
      info_word[IDX_W-1:0] = top_idx;
      info_word[VALID_BIT] = 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (grp)
      GRP_MODE: bus_rdata = mode_word[bsel];
      GRP_MASK: bus_rdata[BANK_LINES-1:0] = mask_all[bsel*BANK_LINES +: BANK_LINES];
      GRP_PEND: bus_rdata[BANK_LINES-1:0] = pend_all[bsel*BANK_LINES +: BANK_LINES];
      default:  if (bsel == '0) bus_rdata = info_word;
    endcase
  end

  // Observation wires for the picker checks.
  logic [IDX_W-1:0]        pick_off;
  logic [SHARED_LINES-1:0] pick_shift;
  assign pick_off   = top_idx - IDX_W'(DIRECT_LINES);
  assign pick_shift = shared_req >> pick_off;

  // R9: the OR output and the picker agree
  p_shared_vs_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shared_irq == top_valid);
  // R10: the picked line is really requesting
  p_pick_is_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> pick_shift[0]);
  // R10: no higher line is requesting
  p_pick_highest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> ((pick_shift >> 1) == '0));
  // R7: a masked line never reaches a dedicated output
  p_direct_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_irq & mask_all[DIRECT_LINES-1:0]) == '0);
endmodule

// File: tb/pin_event_ctrl_test.sv
`timescale 1ns/1ps
module pin_event_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = 32'hFFFF_FFFF;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] direct_irq;
  logic        shared_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pin_event_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .direct_irq(direct_irq), .shared_irq(shared_irq)
  );

  function automatic logic [3:0] a_mode(int b); return 4'(b);      endfunction
  function automatic logic [3:0] a_mask(int b); return 4'(4 + b);  endfunction
  function automatic logic [3:0] a_pend(int b); return 4'(8 + b);  endfunction
  localparam logic [3:0] A_INFO = 4'd12;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int b = 0; b < 4; b++) begin
      rd(a_mode(b), d); chk("R1 mode", d, 32'h0);
      rd(a_mask(b), d); chk("R1 mask", d, 32'hFF);
      rd(a_pend(b), d); chk("R1 pend", d, 32'h0);
    end
    rd(A_INFO, d); chk("R1 info", d, 32'h0);
    chk("R1 direct", {16'h0, direct_irq}, 32'h0);
    chk("R1 shared", {31'h0, shared_irq}, 32'h0);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    wr(a_mode(3), 32'hFFFF_FFFF);
    rd(a_mode(3), d); chk("R2 slot top bit", d, 32'h7777_7777);
    wr(a_mode(3), 32'h5555_5555);
    wr(a_mask(0), 32'hFFFF_FF00);
    rd(a_mask(0), d); chk("R12 mask width", d, 32'h0);
    wr(a_mask(0), 32'hFF);
  endtask

  task automatic t_level_low;
    logic [31:0] d;
    wr(a_mode(0), 32'h5555_0555);   // line 3 level low, others code 5
    wr(a_mask(0), 32'hF7);
    settle(4);
    rd(a_pend(0), d); chk("R5 disabled lines quiet", d, 32'h0);
    pins[3] = 1'b0;
    settle(4);
    rd(a_pend(0), d); chk("R3 level low set", d, 32'h08);
    chk("R8 direct line3", {16'h0, direct_irq}, 32'h0008);
    wr(a_pend(0), 32'h08);
    settle(1);
    rd(a_pend(0), d); chk("R3 re-set after clear", d, 32'h08);
    pins[3] = 1'b1;
    settle(4);
    wr(a_pend(0), 32'hFFFF_FF08);
    rd(a_pend(0), d); chk("R6 clear", d, 32'h0);
    chk("R8 direct off", {16'h0, direct_irq}, 32'h0);
    wr(a_mask(0), 32'hFF);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    wr(a_mode(1), 32'h5555_5537);   // line 9 rising, line 8 code 7
    wr(a_mask(1), 32'hFD);
    @(negedge clk);
    pins[9] = 1'b0; pins[8] = 1'b0;
    settle(4);
    rd(a_pend(1), d); chk("R4 falling ignored by rising", d, 32'h0);
    @(negedge clk);
    pins[9] = 1'b1; pins[8] = 1'b1;
    settle(2);
    peek(a_pend(1), d); chk("R11 not yet after two edges", d, 32'h0);
    settle(1);
    peek(a_pend(1), d); chk("R11 visible after three edges", d, 32'h02);
    chk("R8 direct line9", {16'h0, direct_irq}, 32'h0200);
    settle(3);
    wr(a_pend(1), 32'hFF);
    settle(2);
    rd(a_pend(1), d); chk("R4 steady pin no re-set", d, 32'h0);
    wr(a_mask(1), 32'hFF);
  endtask

  task automatic t_shared;
    logic [31:0] d;
    wr(a_mode(2), 32'h5554_5515);   // line 20 both edges, line 17 level high
    wr(a_mode(3), 32'h5555_2555);   // line 27 falling
    settle(4);
    rd(a_pend(2), d); chk("R3 level high set", d, 32'h02);
    wr(a_pend(2), 32'h00);
    rd(a_pend(2), d); chk("R6 zero write keeps", d, 32'h02);
    chk("R7 masked not shared", {31'h0, shared_irq}, 32'h0);
    pins[20] = 1'b0;
    settle(4);
    rd(a_pend(2), d); chk("R7 masked still pends", d, 32'h12);
    chk("R7 masked shared low", {31'h0, shared_irq}, 32'h0);
    wr(a_mask(2), 32'hEF);
    chk("R9 shared high", {31'h0, shared_irq}, 32'h1);
    rd(A_INFO, d); chk("R10 info line20", d, 32'h114);
    pins[27] = 1'b0;
    settle(4);
    rd(A_INFO, d); chk("R10 masked 27 ignored", d, 32'h114);
    wr(a_mask(3), 32'hF7);
    rd(A_INFO, d); chk("R10 highest first", d, 32'h11B);
    wr(a_pend(3), 32'h08);
    rd(A_INFO, d); chk("R10 falls back", d, 32'h114);
    wr(a_pend(2), 32'h10);
    rd(A_INFO, d); chk("R10 none", d, 32'h0);
    chk("R9 shared low", {31'h0, shared_irq}, 32'h0);
    pins[20] = 1'b1;
    settle(4);
    rd(a_pend(2), d); chk("R4 both rising", d & 32'h10, 32'h10);
    wr(a_pend(2), 32'h10);
    pins[20] = 1'b0;
    settle(4);
    rd(a_pend(2), d); chk("R4 both falling", d & 32'h10, 32'h10);
    pins[27] = 1'b1;
    settle(4);
    wr(a_pend(2), 32'hFF);
    wr(a_pend(3), 32'hFF);
    rd(a_pend(3), d); chk("R4 rise ignored by falling", d, 32'h0);
    chk("R9 shared cleared", {31'h0, shared_irq}, 32'h0);
    chk("R8 direct untouched", {16'h0, direct_irq}, 32'h0);
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_level_low();
    t_rising();
    t_shared();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule